// File: doc/BRIEF.md
# Serial Differential ADC Readout Controller

This block sits in the host and runs one readout transaction with an external 13-bit differential successive-approximation converter over a four-wire serial link: chip select, serial clock, command out and data in. A one-cycle start request carries the input mode and a 3-bit channel number. The controller pulls chip select low and shifts out a 5-bit command. It then clocks the converter through its acquisition and conversion phases and captures the returned bits. It sign-extends the 13-bit two's-complement code into a wider signed result and raises a one-cycle valid strobe.

All serial timing is generated from the fast system clock by three divider counts: the serial clock half period, the chip-select setup time and the chip-select idle time. Each count is compared at elaboration with the minimum that the converter's timing limits imply at the given system clock rate. A count that is too small stops elaboration with an error. The converter needs 210 ns for each clock phase, 100 ns from chip-select fall to the first rising edge, and 475 ns of chip-select high between transactions. A busy flag covers the whole transaction and the idle period that follows it, and start requests are ignored while it is set.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, cs_no is 1, sclk_o is 0, mosi_o is 0, valid_o is 0, busy_o is 0 and result_o is 0.
- R2: The command goes out on mosi_o MSB first, one bit per rising sclk_o edge on edges 1 to 5, in the order: start bit 1, mode bit (1 = single-ended, 0 = differential), then chan_i[2], chan_i[1], chan_i[0]. mosi_o changes only while sclk_o is low.
- R3: Each transaction produces exactly 21 rising sclk_o edges while cs_no is low.
- R4: Each high phase and each low phase of sclk_o lasts HALF_CNT system clocks.
- R5: cs_no falls CS_SETUP_CNT system clocks before the first rising sclk_o edge.
- R6: Between two transactions cs_no stays high for at least CS_HIGH_CNT system clocks, and busy_o stays 1 through that interval.
- R7: The bit sampled at rising edge 7 is a null bit and is discarded. Edge 8 samples the sign bit, and edges 9 to 20 sample data bits 11 down to 0.
- R8: result_o is the 13-bit code sign-extended to RES_W bits. valid_o is a one-cycle pulse in the same cycle that cs_no rises, and result_o then holds until the next transaction completes.
- R9: A start_i pulse while busy_o is 1 is ignored: no command bit, channel or extra transaction results from it.
- R10: sclk_o is never 1 while cs_no is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| single_i | input | 1 | Mode bit: 1 single-ended, 0 differential |
| chan_i | input | 3 | Channel number |
| busy_o | output | 1 | Transaction or chip-select idle period in progress |
| cs_no | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| mosi_o | output | 1 | Serial command to the converter |
| miso_i | input | 1 | Serial data from the converter |
| result_o | output | RES_W | Sign-extended signed conversion result |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
The start request is sampled on a rising clock. cs_no falls on that same edge, the first sclk_o rise follows CS_SETUP_CNT clocks later, and every later phase change follows HALF_CNT clocks after the previous one. valid_o rises on the edge that raises cs_no, one half period after the 21st clock falls. The bench models the converter from the pins and time-stamps every cs_no and sclk_o transition, so the phase widths, setup time and idle gap are checked in nanoseconds against the counts times the 5 ns period. The bench polls result and strobe on falling clock edges, so they are read half a cycle after the registers update. A null bit of opposite polarity to the sign is driven on edge 7, so a capture window that is off by one edge shows up in the result.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HIGH, ST_LOW, ST_TAIL, ST_GAP
  } state_e;

  localparam int CMD_BITS   = 5;
  localparam int FRAME_CLKS = 21;
  localparam int NULL_EDGE  = 7;
  localparam int CODE_W     = 13;

  // smallest cycle count covering ns at mhz
  function automatic int ns_to_cycles(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction
endpackage

// File: rtl/adc_rd_timer.sv
`timescale 1ns/1ps
module adc_rd_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_cmd_tx.sv
`timescale 1ns/1ps
module adc_rd_cmd_tx #(
  parameter int CMD_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             shift_i,
  output logic             bit_o
);
  logic [CMD_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sreg_q <= '0;
    else if (load_i)   sreg_q <= cmd_i;
    else if (shift_i)  sreg_q <= {sreg_q[CMD_W-2:0], 1'b0};
  end

  assign bit_o = sreg_q[CMD_W-1];
endmodule

// File: rtl/adc_rd_capture.sv
`timescale 1ns/1ps
module adc_rd_capture #(
  parameter int CODE_W     = 13,
  parameter int RES_W      = 16,
  parameter int EDGE_W     = 5,
  parameter int FIRST_EDGE = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [EDGE_W-1:0] edge_num_i,
  input  logic              miso_i,
  input  logic              done_i,
  output logic [RES_W-1:0]  result_o,
  output logic              valid_o
);
  localparam logic [EDGE_W-1:0] LO_EDGE = EDGE_W'(FIRST_EDGE);
  localparam logic [EDGE_W-1:0] HI_EDGE = EDGE_W'(FIRST_EDGE + CODE_W - 1);

  if (RES_W <= CODE_W) begin : g_res_w_err
    $error("RES_W must exceed CODE_W");
  end

  logic [CODE_W-1:0] code_q;
  logic              in_win;

  assign in_win = sample_i && (edge_num_i >= LO_EDGE) && (edge_num_i <= HI_EDGE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_q <= '0;
    else if (in_win) code_q <= {code_q[CODE_W-2:0], miso_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (done_i) result_o <= {{(RES_W-CODE_W){code_q[CODE_W-1]}}, code_q};
    end
  end

  // R8
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R8
  sign_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(result_o[RES_W-1:CODE_W-1]) == 0 ||
                 $countones(result_o[RES_W-1:CODE_W-1]) == RES_W-CODE_W+1));
endmodule

// File: rtl/adc_rd_ctrl.sv
`timescale 1ns/1ps
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int SYS_CLK_MHZ  = 200,
  parameter int HALF_CNT     = 50,
  parameter int CS_SETUP_CNT = 24,
  parameter int CS_HIGH_CNT  = 100,
  parameter int RES_W        = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             single_i,
  input  logic [2:0]       chan_i,
  output logic             busy_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o
);
  localparam int MIN_HALF  = ns_to_cycles(210, SYS_CLK_MHZ);
  localparam int MIN_SETUP = ns_to_cycles(100, SYS_CLK_MHZ);
  localparam int MIN_CSH   = ns_to_cycles(475, SYS_CLK_MHZ);
  localparam int MAX_A     = (HALF_CNT > CS_SETUP_CNT) ? HALF_CNT : CS_SETUP_CNT;
  localparam int MAX_CNT   = (MAX_A > CS_HIGH_CNT) ? MAX_A : CS_HIGH_CNT;
  localparam int CNT_W     = $clog2(MAX_CNT + 1);
  localparam int RUN_W     = CNT_W + 1;
  localparam int EDGE_W    = $clog2(FRAME_CLKS + 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(FRAME_CLKS);

  if (HALF_CNT < MIN_HALF) begin : g_half_err
    $error("HALF_CNT below 210 ns clock phase minimum");
  end
  if (CS_SETUP_CNT < MIN_SETUP) begin : g_setup_err
    $error("CS_SETUP_CNT below 100 ns select setup minimum");
  end
  if (CS_HIGH_CNT < MIN_CSH) begin : g_csh_err
    $error("CS_HIGH_CNT below 475 ns select idle minimum");
  end

  state_e            state_q, state_d;
  logic [CNT_W-1:0]  dur;
  logic              go, tmr_zero;
  logic              sclk_q, sclk_d, cs_n_q, cs_n_d;
  logic [EDGE_W-1:0] edge_q;
  logic              start_ok, rise_now, fall_now, done;

  assign start_ok = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    dur     = '0;
    unique case (state_q)
      ST_IDLE:  if (start_i) begin
                  state_d = ST_SETUP;
                  dur     = CNT_W'(CS_SETUP_CNT - 1);
                end
      ST_SETUP: if (tmr_zero) begin
                  state_d = ST_HIGH;
                  dur     = CNT_W'(HALF_CNT - 1);
                end
      ST_HIGH:  if (tmr_zero) begin
                  state_d = (edge_q == LAST_EDGE) ? ST_TAIL : ST_LOW;
                  dur     = CNT_W'(HALF_CNT - 1);
                end
      ST_LOW:   if (tmr_zero) begin
                  state_d = ST_HIGH;
                  dur     = CNT_W'(HALF_CNT - 1);
                end
      ST_TAIL:  if (tmr_zero) begin
                  state_d = ST_GAP;
                  dur     = CNT_W'(CS_HIGH_CNT - 1);
                end
      ST_GAP:   if (tmr_zero) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign go       = (state_d != state_q);
  assign rise_now = go && (state_d == ST_HIGH);
  assign fall_now = go && (state_q == ST_HIGH);
  assign done     = go && (state_d == ST_GAP);
  assign sclk_d   = (state_d == ST_HIGH);
  assign cs_n_d   = (state_d == ST_IDLE) || (state_d == ST_GAP);

  adc_rd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(go), .val_i(dur), .zero_o(tmr_zero)
  );

  adc_rd_cmd_tx #(.CMD_W(CMD_BITS)) u_cmd (
    .clk_i, .rst_ni,
    .load_i (start_ok),
    .cmd_i  ({1'b1, single_i, chan_i}),
    .shift_i(fall_now),
    .bit_o  (mosi_o)
  );

  adc_rd_capture #(
    .CODE_W(CODE_W), .RES_W(RES_W), .EDGE_W(EDGE_W), .FIRST_EDGE(NULL_EDGE + 1)
  ) u_cap (
    .clk_i, .rst_ni,
    .sample_i  (rise_now),
    .edge_num_i(edge_q + 1'b1),
    .miso_i,
    .done_i    (done),
    .result_o,
    .valid_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      edge_q  <= '0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
      if (start_ok)      edge_q <= '0;
      else if (rise_now) edge_q <= edge_q + 1'b1;
    end
  end

  assign sclk_o = sclk_q;
  assign cs_no  = cs_n_q;
  assign busy_o = (state_q != ST_IDLE);

  // cycles each pin has held its present level, saturating
  logic [RUN_W-1:0] sclk_run_q, cs_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_run_q <= '1;
      cs_run_q   <= '1;
    end else begin
      if (sclk_d != sclk_q)      sclk_run_q <= RUN_W'(1);
      else if (sclk_run_q != '1) sclk_run_q <= sclk_run_q + 1'b1;
      if (cs_n_d != cs_n_q)      cs_run_q   <= RUN_W'(1);
      else if (cs_run_q != '1)   cs_run_q   <= cs_run_q + 1'b1;
    end
  end

  // R10
  sclk_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);

  // R4
  half_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_d != sclk_q && !cs_n_q) |-> sclk_run_q >= RUN_W'(MIN_HALF));

  // R5
  cs_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_d && !sclk_q && edge_q == '0) |-> (!cs_n_q && cs_run_q >= RUN_W'(MIN_SETUP)));

  // R6
  cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_q && !cs_n_d) |-> cs_run_q >= RUN_W'(MIN_CSH));

  // R3
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> edge_q == LAST_EDGE);

  // R2
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));

  // R6
  busy_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> busy_o);
endmodule

// File: tb/adc_rd_ctrl_test.sv
`timescale 1ns/1ps
module adc_rd_ctrl_test;
  localparam int HALF = 50, SETUP = 24, CSH = 100, RW = 16;
  localparam real TCK = 5.0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, single = 1'b0, miso = 1'b1;
  logic [2:0] chan = '0;
  logic busy, cs_n, sclk, mosi, valid;
  logic [RW-1:0] result;

  always #2.5 clk = ~clk;

  adc_rd_ctrl #(.SYS_CLK_MHZ(200), .HALF_CNT(HALF), .CS_SETUP_CNT(SETUP),
                .CS_HIGH_CNT(CSH), .RES_W(RW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .single_i(single), .chan_i(chan),
    .busy_o(busy), .cs_no(cs_n), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso),
    .result_o(result), .valid_o(valid));

  int checks = 0, fails = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model and pin timing monitor
  logic [12:0] adc_code = '0;
  logic [4:0]  cmd_rx = '0;
  int rise_n = 0, frame_rises = 0, cs_falls = 0, sclk_bad = 0, mosi_bad = 0;
  realtime t_cs_fall = 0, t_cs_rise = 0, t_rise = 0, t_fall = 0;
  real setup_w = 0, gap_w = 0, hi_min = 0, hi_max = 0, lo_min = 0, lo_max = 0;

  always @(negedge cs_n) begin
    t_cs_fall = $realtime;
    gap_w = t_cs_fall - t_cs_rise;
    rise_n = 0; cmd_rx = '0; cs_falls++;
    hi_min = 1.0e9; hi_max = 0; lo_min = 1.0e9; lo_max = 0;
  end

  always @(posedge cs_n) begin
    t_cs_rise = $realtime;
    frame_rises = rise_n;
  end

  always @(posedge sclk) begin
    rise_n++;
    if (cs_n !== 1'b0) sclk_bad++;
    if (rise_n == 1) setup_w = $realtime - t_cs_fall;
    else begin
      if ($realtime - t_fall < lo_min) lo_min = $realtime - t_fall;
      if ($realtime - t_fall > lo_max) lo_max = $realtime - t_fall;
    end
    if (rise_n <= 5) cmd_rx = {cmd_rx[3:0], mosi};
    t_rise = $realtime;
  end

  always @(negedge sclk) begin
    int nk;
    if (rise_n > 0) begin
      if ($realtime - t_rise < hi_min) hi_min = $realtime - t_rise;
      if ($realtime - t_rise > hi_max) hi_max = $realtime - t_rise;
    end
    t_fall = $realtime;
    nk = rise_n + 1;
    #20;
    if (nk == 7)                miso = ~adc_code[12];
    else if (nk == 8)           miso = adc_code[12];
    else if (nk >= 9 && nk <= 20) miso = adc_code[20-nk];
    else                        miso = 1'b1;
  end

  always @(mosi) if (sclk === 1'b1) mosi_bad++;

  task automatic wait_idle();
    @(negedge clk);
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic pulse_start(input logic s, input logic [2:0] c);
    single = s; chan = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid(output bit seen);
    seen = 0;
    for (int i = 0; i < 6000; i++) begin
      if (valid) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic check_frame(input logic s, input logic [2:0] c, input logic [12:0] code);
    int exp_v;
    exp_v = code[12] ? int'(code) - 8192 : int'(code);
    chk("R8 strobe with select high", int'(cs_n), 1);
    chk("R8 sign-extended result", int'($signed(result)), exp_v);
    chk("R7 null bit skipped, sign at edge 8", int'(result[12]), int'(code[12]));
    chk("R2 command bits", int'(cmd_rx), int'({1'b1, s, c}));
    chk("R3 rising edges per frame", frame_rises, 21);
    chk("R4 high phase min ns", int'(hi_min), int'(HALF * TCK));
    chk("R4 high phase max ns", int'(hi_max), int'(HALF * TCK));
    chk("R4 low phase min ns", int'(lo_min), int'(HALF * TCK));
    chk("R4 low phase max ns", int'(lo_max), int'(HALF * TCK));
    chk("R5 select setup ns", int'(setup_w), int'(SETUP * TCK));
    chk("R10 clock outside frame", sclk_bad, 0);
    chk("R2 command line moved while clock high", mosi_bad, 0);
    @(negedge clk);
    chk("R8 strobe is one cycle", int'(valid), 0);
    chk("R8 result held", int'($signed(result)), exp_v);
    chk("R6 busy during select idle", int'(busy), 1);
  endtask

  task automatic run_conv(input logic s, input logic [2:0] c, input logic [12:0] code);
    bit seen;
    adc_code = code;
    wait_idle();
    pulse_start(s, c);
    wait_valid(seen);
    chk("R8 strobe arrives", int'(seen), 1);
    check_frame(s, c, code);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 select high", int'(cs_n), 1);
    chk("R1 clock low", int'(sclk), 0);
    chk("R1 command low", int'(mosi), 0);
    chk("R1 strobe low", int'(valid), 0);
    chk("R1 busy low", int'(busy), 0);
    chk("R1 result zero", int'(result), 0);
  endtask

  task automatic t_codes();
    run_conv(1'b0, 3'd0, 13'h0FFF);
    run_conv(1'b1, 3'd7, 13'h1000);
    run_conv(1'b0, 3'd5, 13'h1FFF);
    run_conv(1'b1, 3'd2, 13'h0000);
    run_conv(1'b1, 3'd4, 13'h0AAA);
    run_conv(1'b0, 3'd1, 13'h1555);
    run_conv(1'b1, 3'd6, 13'h0001);
  endtask

  task automatic t_busy_ignore();
    bit seen;
    int falls0;
    adc_code = 13'h1234;
    wait_idle();
    falls0 = cs_falls;
    pulse_start(1'b1, 3'd3);
    repeat (300) @(negedge clk);
    pulse_start(1'b0, 3'd6);
    wait_valid(seen);
    chk("R9 strobe arrives", int'(seen), 1);
    check_frame(1'b1, 3'd3, 13'h1234);
    pulse_start(1'b0, 3'd6);
    repeat (400) @(negedge clk);
    chk("R9 no extra transaction", cs_falls - falls0, 1);
    chk("R9 idle afterwards", int'(busy), 0);
  endtask

  task automatic t_back_to_back();
    run_conv(1'b0, 3'd2, 13'h0800);
    run_conv(1'b1, 3'd5, 13'h17FF);
    checks++;
    if (gap_w < CSH * TCK) begin
      fails++;
      $display("FAIL R6 select idle gap actual=%0d expected>=%0d", int'(gap_w), int'(CSH * TCK));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_codes();
    t_busy_ignore();
    t_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule